// File: doc/BRIEF.md
# IDE PIO Cycle Timing Sequencer

This block sits between a local processor bus and two IDE channels. When the bus starts an I/O cycle at one of the two eight-port IDE command blocks, the block decides which channel and which drive the cycle targets. It then counts out a setup interval, asserts the IDE read or write strobe for an active interval, and returns a one-clock ready pulse to the bus in the last strobe clock. The interval lengths come from 4-bit timing fields supplied by an external register file. Each field has a fixed offset added to it, so a field value of zero still gives a safe minimum.

A 16-bit access makes one IDE strobe. A 32-bit access to the data port makes two 16-bit strobes with a recovery gap between them. The low word moves first, and the two read halves are joined on the bus side. The block records which drive each channel has selected by watching writes to the drive/head port. That record picks master or slave timing for later cycles. The drive-select write itself still uses the setup time of the drive it replaces.

Top module: `ide_pio_sequencer`

## Requirements
- R1: A cycle start at 0x1F0..0x1F7 targets the primary channel (channel 0) and one at 0x170..0x177 targets the secondary channel (channel 1). The low three address bits appear on `ide_addr_o` while the strobe is active. A start at any other address produces no strobe and no ready.
- R2: The strobe first asserts S = 4 + n clocks after the edge that samples the start. The value n comes from `setup_pri_i` for channel 0 and from `setup_sec_i` for channel 1, using bits [3:0] when the master drive is selected and bits [7:4] when the slave drive is selected.
- R3: For any port other than offset 0 (the data port), the strobe stays high for 3 + `cmd_act_i` clocks, whatever the channel or drive.
- R4: For a data-port read, the active time is 3 + the high nibble and the recovery time is 4 + the low nibble of byte k of `rd_tim_i`, where k = 2*channel + drive (drive 1 = slave) and byte k is bits [8k+7:8k].
- R5: A data-port write follows R4 but takes byte k of `wr_tim_i`.
- R6: A 32-bit data-port access makes two strobes with a recovery gap between them. A 32-bit access to any other port makes a single strobe.
- R7: `cyc_ready_o` is high for exactly the last clock of the final strobe of a cycle and at no other time.
- R8: Every write to offset 6 of a channel stores data bit 4 as that channel's drive select (1 = slave). The store affects later cycles only, so that write uses the setup value of the previously selected drive. After reset both channels select the master drive.
- R9: During ready, `cyc_rdata_o` carries {16'h0, `ide_rdata_i`} for a 16-bit read. For a 32-bit data read it carries {`ide_rdata_i`, word sampled in the last clock of the first strobe}. At all other times it is zero.
- R10: `ide_wdata_o` holds bits [15:0] of the write data during the first strobe and bits [31:16] during the second.
- R11: A cycle start is ignored from the sampling edge of an accepted start through the clock that carries ready.
- R12: Bit c of `ide_rd_o` (read) or `ide_wr_o` (write) is the only strobe driven for channel c, at most one strobe is high at any time, and all strobes and ready are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start_i | input | 1 | Local-bus cycle start (address strobe) |
| cyc_addr_i | input | 16 | I/O address of the cycle |
| cyc_write_i | input | 1 | 1 = write, 0 = read |
| cyc_dword_i | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| cyc_wdata_i | input | 32 | Write data, sampled with the start |
| cyc_ready_o | output | 1 | Cycle completion pulse |
| cyc_rdata_o | output | 32 | Read data, valid while ready is high |
| setup_pri_i | input | 8 | Primary setup nibbles {slave, master} |
| setup_sec_i | input | 8 | Secondary setup nibbles {slave, master} |
| cmd_act_i | input | 4 | Global non-data active nibble |
| rd_tim_i | input | 32 | Four data-read timing bytes {active, recovery} |
| wr_tim_i | input | 32 | Four data-write timing bytes {active, recovery} |
| ide_rd_o | output | 2 | Per-channel read strobes, active high |
| ide_wr_o | output | 2 | Per-channel write strobes, active high |
| ide_addr_o | output | 3 | IDE register offset |
| ide_wdata_o | output | 16 | IDE write data |
| ide_rdata_i | input | 16 | IDE read data |

## Verification
A wrong countdown or a wrongly latched timing field shifts the strobe edges and the ready pulse by whole clocks, so a per-clock comparison against the model catches it in the first cycle where the edge is off. A drive-select record that is stale or updated too early does not show up on the cycle that writes it. It appears only in the setup length of the next cycle on that channel. For this reason the bench always follows a drive-select write with a timed access. A wrong captured low word stays hidden until the ready clock of a 32-bit read, where it appears in bits [15:0] of the read data.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_RECOV  = 2'd3
   } seq_state_e;

   // request fields latched when a cycle is launched
   typedef struct packed {
      logic       chan;
      logic [2:0] off;
      logic       write;
      logic       dword;
   } cyc_req_t;

   localparam int unsigned NUM_CHAN    = 2;
   localparam int unsigned DRV_PER_CH  = 2;
   localparam logic [2:0]  OFF_DATA    = 3'd0;
   localparam logic [2:0]  OFF_DRVHEAD = 3'd6;

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] PRI_BASE = 16'h01F0,
   parameter logic [ADDR_W-1:0] SEC_BASE = 16'h0170
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              chan,
   output logic [2:0]        off
);
   logic [1:0] ch_hit;

   for (genvar c = 0; c < 2; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = (c == 0) ? PRI_BASE : SEC_BASE;
      assign ch_hit[c] = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
   end

   assign hit  = |ch_hit;
   assign chan = ch_hit[1];
   assign off  = addr[2:0];
endmodule

// File: rtl/ide_drive_track.sv
module ide_drive_track #(
   parameter int unsigned NCH    = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DRV_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              chan,
   input  logic [DATA_W-1:0] wdata,
   output logic [NCH-1:0]    drv
);
   for (genvar c = 0; c < NCH; c++) begin : g_trk
      always_ff @(posedge clk) begin
         if (!rst_n)
            drv[c] <= 1'b0;
         else if (upd && (chan == c[0]))
            drv[c] <= wdata[DRV_BIT];
      end
   end
endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select #(
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned SETUP_OFS = 4,
   parameter int unsigned ACT_OFS   = 3,
   parameter int unsigned REC_OFS   = 4
) (
   input  logic               chan,
   input  logic               drv,
   input  logic               is_data,
   input  logic               write,
   input  logic [2*NIB_W-1:0] setup_pri,
   input  logic [2*NIB_W-1:0] setup_sec,
   input  logic [NIB_W-1:0]   cmd_act,
   input  logic [8*NIB_W-1:0] rd_tim,
   input  logic [8*NIB_W-1:0] wr_tim,
   output logic [CNT_W-1:0]   setup_len,
   output logic [CNT_W-1:0]   act_len,
   output logic [CNT_W-1:0]   rec_len
);
   localparam int unsigned BYTE_W = 2 * NIB_W;

   logic [BYTE_W-1:0] setup_pair;
   logic [NIB_W-1:0]  setup_nib;
   logic [1:0]        idx;
   logic [BYTE_W-1:0] dat_byte;
   logic [NIB_W-1:0]  act_nib;

   assign setup_pair = chan ? setup_sec : setup_pri;
   assign setup_nib  = drv ? setup_pair[BYTE_W-1:NIB_W] : setup_pair[NIB_W-1:0];
   assign idx        = {chan, drv};
   assign dat_byte   = write ? wr_tim[idx*BYTE_W +: BYTE_W] : rd_tim[idx*BYTE_W +: BYTE_W];
   assign act_nib    = is_data ? dat_byte[BYTE_W-1:NIB_W] : cmd_act;

   assign setup_len = CNT_W'(setup_nib) + CNT_W'(SETUP_OFS);
   assign act_len   = CNT_W'(act_nib) + CNT_W'(ACT_OFS);
   assign rec_len   = CNT_W'(dat_byte[NIB_W-1:0]) + CNT_W'(REC_OFS);
endmodule

// File: rtl/ide_phase_ctrl.sv
module ide_phase_ctrl
   import ide_seq_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             two_beat,
   input  logic [CNT_W-1:0] setup_len,
   input  logic [CNT_W-1:0] act_len,
   input  logic [CNT_W-1:0] rec_len,
   output logic             busy,
   output logic             strobe_on,
   output logic             beat,
   output logic             cap_lo,
   output logic             done
);
   seq_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_q;
   logic [CNT_W-1:0] rec_q;
   logic             two_q;
   logic             last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         act_q <= '0;
         rec_q <= '0;
         two_q <= 1'b0;
         beat  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (launch) begin
                  st    <= ST_SETUP;
                  cnt   <= setup_len - CNT_W'(1);
                  act_q <= act_len;
                  rec_q <= rec_len;
                  two_q <= two_beat;
                  beat  <= 1'b0;
               end
            end
            ST_SETUP, ST_RECOV: begin
               if (cnt == '0) begin
                  st  <= ST_ACTIVE;
                  cnt <= act_q - CNT_W'(1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_ACTIVE: begin
               if (cnt == '0) begin
                  if (two_q && !beat) begin
                     st   <= ST_RECOV;
                     cnt  <= rec_q - CNT_W'(1);
                     beat <= 1'b1;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign strobe_on = (st == ST_ACTIVE);
   assign last      = strobe_on && (cnt == '0);
   assign done      = last && (beat || !two_q);
   assign cap_lo    = last && !done;
endmodule

// File: rtl/ide_pio_sequencer.sv
module ide_pio_sequencer
   import ide_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned SETUP_OFS = 4,
   parameter int unsigned ACT_OFS   = 3,
   parameter int unsigned REC_OFS   = 4,
   parameter int unsigned DRV_BIT   = 4,
   parameter logic [ADDR_W-1:0] PRI_BASE = 16'h01F0,
   parameter logic [ADDR_W-1:0] SEC_BASE = 16'h0170
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cyc_start_i,
   input  logic [ADDR_W-1:0]    cyc_addr_i,
   input  logic                 cyc_write_i,
   input  logic                 cyc_dword_i,
   input  logic [2*WORD_W-1:0]  cyc_wdata_i,
   output logic                 cyc_ready_o,
   output logic [2*WORD_W-1:0]  cyc_rdata_o,
   input  logic [2*NIB_W-1:0]   setup_pri_i,
   input  logic [2*NIB_W-1:0]   setup_sec_i,
   input  logic [NIB_W-1:0]     cmd_act_i,
   input  logic [8*NIB_W-1:0]   rd_tim_i,
   input  logic [8*NIB_W-1:0]   wr_tim_i,
   output logic [1:0]           ide_rd_o,
   output logic [1:0]           ide_wr_o,
   output logic [2:0]           ide_addr_o,
   output logic [WORD_W-1:0]    ide_wdata_o,
   input  logic [WORD_W-1:0]    ide_rdata_i
);
   localparam int unsigned BUS_W = 2 * WORD_W;
   localparam int unsigned CNT_W = NIB_W + 1;

   if (NIB_W < 1 || NIB_W > 8) begin : g_bad_nib
      $error("NIB_W must be 1..8");
   end
   if (SETUP_OFS < 1 || ACT_OFS < 1 || REC_OFS < 1) begin : g_bad_ofs
      $error("timing offsets must be at least 1");
   end
   if (SETUP_OFS > (1 << NIB_W) || ACT_OFS > (1 << NIB_W) || REC_OFS > (1 << NIB_W)) begin : g_big_ofs
      $error("timing offsets overflow the counter");
   end
   if (DRV_BIT >= BUS_W) begin : g_bad_drv
      $error("DRV_BIT outside write data");
   end
   if (PRI_BASE[2:0] != 3'd0 || SEC_BASE[2:0] != 3'd0) begin : g_bad_base
      $error("channel bases must be 8-aligned");
   end

   logic             hit;
   logic             dec_chan;
   logic [2:0]       dec_off;
   logic             seq_busy;
   logic             launch;
   logic             is_data;
   logic [1:0]       drv_q;
   logic [CNT_W-1:0] setup_len, act_len, rec_len;
   logic             strobe_on, beat, cap_lo, done;
   cyc_req_t         req_q;
   logic [BUS_W-1:0] wdata_q;
   logic [WORD_W-1:0] lo_q;

   ide_addr_decode #(
      .ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE)
   ) u_dec (
      .addr(cyc_addr_i), .hit(hit), .chan(dec_chan), .off(dec_off)
   );

   assign launch  = cyc_start_i && hit && !seq_busy;
   assign is_data = (dec_off == OFF_DATA);

   ide_drive_track #(
      .NCH(NUM_CHAN), .DATA_W(BUS_W), .DRV_BIT(DRV_BIT)
   ) u_trk (
      .clk(clk), .rst_n(rst_n),
      .upd(launch && cyc_write_i && (dec_off == OFF_DRVHEAD)),
      .chan(dec_chan), .wdata(cyc_wdata_i), .drv(drv_q)
   );

   ide_timing_select #(
      .NIB_W(NIB_W), .CNT_W(CNT_W),
      .SETUP_OFS(SETUP_OFS), .ACT_OFS(ACT_OFS), .REC_OFS(REC_OFS)
   ) u_tsel (
      .chan(dec_chan), .drv(drv_q[dec_chan]), .is_data(is_data),
      .write(cyc_write_i),
      .setup_pri(setup_pri_i), .setup_sec(setup_sec_i), .cmd_act(cmd_act_i),
      .rd_tim(rd_tim_i), .wr_tim(wr_tim_i),
      .setup_len(setup_len), .act_len(act_len), .rec_len(rec_len)
   );

   ide_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .two_beat(is_data && cyc_dword_i),
      .setup_len(setup_len), .act_len(act_len), .rec_len(rec_len),
      .busy(seq_busy), .strobe_on(strobe_on), .beat(beat),
      .cap_lo(cap_lo), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= '0;
         wdata_q <= '0;
         lo_q    <= '0;
      end else begin
         if (launch) begin
            req_q.chan  <= dec_chan;
            req_q.off   <= dec_off;
            req_q.write <= cyc_write_i;
            req_q.dword <= is_data && cyc_dword_i;
            wdata_q     <= cyc_wdata_i;
         end
         if (cap_lo)
            lo_q <= ide_rdata_i;
      end
   end

   always_comb begin
      ide_rd_o = '0;
      ide_wr_o = '0;
      if (strobe_on) begin
         if (req_q.write) ide_wr_o[req_q.chan] = 1'b1;
         else             ide_rd_o[req_q.chan] = 1'b1;
      end
   end

   assign ide_addr_o  = req_q.off;
   assign ide_wdata_o = beat ? wdata_q[BUS_W-1:WORD_W] : wdata_q[WORD_W-1:0];
   assign cyc_ready_o = done;

   always_comb begin
      cyc_rdata_o = '0;
      if (done && !req_q.write)
         cyc_rdata_o = req_q.dword ? {ide_rdata_i, lo_q} : {{WORD_W{1'b0}}, ide_rdata_i};
   end
endmodule

// File: rtl/ide_pio_sequencer_chk.sv
module ide_pio_sequencer_chk #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned SETUP_OFS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seq_busy,
   input logic [1:0]        ide_rd_o,
   input logic [1:0]        ide_wr_o,
   input logic [2:0]        ide_addr_o,
   input logic [WORD_W-1:0] ide_wdata_o,
   input logic              cyc_ready_o
);
   logic       strb;
   logic [7:0] since_go;

   assign strb = |{ide_rd_o, ide_wr_o};

   always_ff @(posedge clk) begin
      if (!rst_n || !seq_busy) since_go <= '0;
      else if (since_go != 8'hFF) since_go <= since_go + 8'd1;
   end

   a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ide_rd_o, ide_wr_o}));

   a_r7_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ready_o |-> strb);

   a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ready_o |=> !cyc_ready_o);

   a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (!strb && !cyc_ready_o));

   a_r2_setup_floor: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> (since_go >= 8'(SETUP_OFS)));

   a_r1_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && $past(strb)) |-> $stable(ide_addr_o));

   a_r10_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ide_wr_o) && $past(|ide_wr_o)) |-> $stable(ide_wdata_o));
endmodule

bind ide_pio_sequencer ide_pio_sequencer_chk #(
   .WORD_W(WORD_W), .SETUP_OFS(SETUP_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .seq_busy(seq_busy),
   .ide_rd_o(ide_rd_o), .ide_wr_o(ide_wr_o), .ide_addr_o(ide_addr_o),
   .ide_wdata_o(ide_wdata_o), .cyc_ready_o(cyc_ready_o)
);

// File: tb/ide_pio_sequencer_tb.sv
module ide_pio_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start_i = 1'b0;
   logic [15:0] cyc_addr_i = '0;
   logic        cyc_write_i = 1'b0;
   logic        cyc_dword_i = 1'b0;
   logic [31:0] cyc_wdata_i = '0;
   logic        cyc_ready_o;
   logic [31:0] cyc_rdata_o;
   logic [7:0]  setup_pri_i = 8'h52;
   logic [7:0]  setup_sec_i = 8'h0F;
   logic [3:0]  cmd_act_i = 4'd5;
   logic [31:0] rd_tim_i = {8'h4A, 8'hF0, 8'h20, 8'h31};
   logic [31:0] wr_tim_i = {8'h15, 8'h6C, 8'h72, 8'h83};
   logic [1:0]  ide_rd_o, ide_wr_o;
   logic [2:0]  ide_addr_o;
   logic [15:0] ide_wdata_o;
   logic [15:0] ide_rdata_i = '0;

   always #2 clk = ~clk;

   ide_pio_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .cyc_addr_i(cyc_addr_i),
      .cyc_write_i(cyc_write_i), .cyc_dword_i(cyc_dword_i), .cyc_wdata_i(cyc_wdata_i),
      .cyc_ready_o(cyc_ready_o), .cyc_rdata_o(cyc_rdata_o),
      .setup_pri_i(setup_pri_i), .setup_sec_i(setup_sec_i), .cmd_act_i(cmd_act_i),
      .rd_tim_i(rd_tim_i), .wr_tim_i(wr_tim_i),
      .ide_rd_o(ide_rd_o), .ide_wr_o(ide_wr_o), .ide_addr_o(ide_addr_o),
      .ide_wdata_o(ide_wdata_o), .ide_rdata_i(ide_rdata_i)
   );

   typedef struct {
      logic [3:0] strb;   // {wr[1:0], rd[1:0]}
      bit         rdy;
      bit         cap;
      bit         hi;
      int         tag;
   } slot_t;

   slot_t q[$];
   int    errors = 0;
   int    checks = 0;
   int    cycn = 0;
   int    idle_tag = 12;
   bit    mdrv[2] = '{1'b0, 1'b0};
   bit    m_dw, m_w;
   logic [2:0]  m_off;
   logic [31:0] m_wd;
   logic [15:0] m_lo;
   bit    done_flag = 0;

   function automatic string tname(int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
      endcase
   endfunction

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL R12 watchdog expired: actual=hung expected=complete");
      finish_run();
   end

   bit was_idle;

   // compare the cycle that has just settled against the model
   task automatic compare();
      slot_t e;
      logic [31:0] exp_rd;
      int t;
      was_idle = (q.size() == 0);
      if (was_idle) e = '{strb: 4'b0, rdy: 0, cap: 0, hi: 0, tag: idle_tag};
      else e = q.pop_front();
      t = e.tag;
      exp_rd = '0;
      if (e.rdy && !m_w) begin
         exp_rd = m_dw ? {ide_rdata_i, m_lo} : {16'h0, ide_rdata_i};
         t = 9;
      end
      checks++;
      if ({ide_wr_o, ide_rd_o} !== e.strb || cyc_ready_o !== e.rdy) begin
         errors++;
         $display("FAIL %s cycle %0d: actual strb=%b rdy=%b expected strb=%b rdy=%b",
                  tname(e.rdy ? 7 : e.tag), cycn, {ide_wr_o, ide_rd_o}, cyc_ready_o, e.strb, e.rdy);
      end
      if (cyc_rdata_o !== exp_rd) begin
         errors++;
         $display("FAIL %s cycle %0d: actual rdata=%h expected=%h", tname(t), cycn, cyc_rdata_o, exp_rd);
      end
      if (e.strb != 0 && ide_addr_o !== m_off) begin
         errors++;
         $display("FAIL R1 cycle %0d: actual addr=%0d expected=%0d", cycn, ide_addr_o, m_off);
      end
      if (e.strb[3:2] != 0 && ide_wdata_o !== (e.hi ? m_wd[31:16] : m_wd[15:0])) begin
         errors++;
         $display("FAIL R10 cycle %0d: actual wdata=%h expected=%h", cycn, ide_wdata_o,
                  e.hi ? m_wd[31:16] : m_wd[15:0]);
      end
      if (e.cap) m_lo = ide_rdata_i;
   endtask

   task automatic push_n(int n, logic [3:0] s, bit hi, int tag);
      for (int i = 0; i < n; i++) q.push_back('{strb: s, rdy: 0, cap: 0, hi: hi, tag: tag});
   endtask

   task automatic model_accept(logic [15:0] a, bit w, bit dw, logic [31:0] wd);
      int ch, idx, s, act, rec, atag;
      bit drv, data, two;
      logic [7:0] tb, sp;
      logic [3:0] sb;
      if (a[15:3] == 13'h1F0 >> 0 >> 0 && 0) ch = 0;
      if (a[15:3] == 16'h01F0 >> 3) ch = 0;
      else if (a[15:3] == 16'h0170 >> 3) ch = 1;
      else return;
      data = (a[2:0] == 0);
      drv  = mdrv[ch];
      sp   = ch ? setup_sec_i : setup_pri_i;
      s    = 4 + int'(drv ? sp[7:4] : sp[3:0]);
      idx  = ch * 2 + int'(drv);
      tb   = w ? wr_tim_i[idx*8 +: 8] : rd_tim_i[idx*8 +: 8];
      act  = 3 + int'(data ? tb[7:4] : cmd_act_i);
      rec  = 4 + int'(tb[3:0]);
      two  = data && dw;
      if (w && a[2:0] == 3'd6) mdrv[ch] = wd[4];
      m_dw = two; m_w = w; m_off = a[2:0]; m_wd = wd;
      sb = '0; sb[(w ? 2 : 0) + ch] = 1'b1;
      atag = data ? (w ? 5 : 4) : 3;
      push_n(s, 4'b0, 0, 2);
      push_n(act - 1, sb, 0, atag);
      q.push_back('{strb: sb, rdy: !two, cap: two, hi: 0, tag: atag});
      if (two) begin
         push_n(rec, 4'b0, 1, 6);
         push_n(act - 1, sb, 1, 6);
         q.push_back('{strb: sb, rdy: 1, cap: 0, hi: 1, tag: 6});
      end
   endtask

   task automatic tick(bit st, logic [15:0] a, bit w, bit dw, logic [31:0] wd);
      @(negedge clk);
      cycn++;
      ide_rdata_i = 16'h3C00 ^ 16'(cycn * 16'h0137);
      #1;
      compare();
      cyc_start_i = st; cyc_addr_i = a; cyc_write_i = w; cyc_dword_i = dw; cyc_wdata_i = wd;
      if (st && was_idle) model_accept(a, w, dw, wd);
   endtask

   task automatic idle_ticks(int n);
      for (int i = 0; i < n; i++) tick(0, 16'h0, 0, 0, 32'h0);
   endtask

   task automatic op(logic [15:0] a, bit w, bit dw, logic [31:0] wd, int tag);
      idle_tag = tag;
      tick(1, a, w, dw, wd);
      while (q.size() != 0) tick(0, 16'h0, 0, 0, 32'h0);
      idle_ticks(2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      idle_tag = 12; idle_ticks(3);                    // R12 reset state
      op(16'h01F1, 0, 0, 32'h0, 3);                    // R3 non-data read, primary master
      op(16'h01F3, 1, 0, 32'h0000_BEEF, 3);            // R3 non-data write
      op(16'h01F0, 0, 0, 32'h0, 4);                    // R4 word data read
      op(16'h01F0, 0, 1, 32'h0, 9);                    // R9 R6 dword data read
      op(16'h01F0, 1, 1, 32'hCAFE_1234, 10);           // R5 R10 dword write
      op(16'h01F6, 1, 0, 32'h0000_0010, 8);            // R8 select slave, master setup
      op(16'h01F0, 0, 1, 32'h0, 8);                    // R8 slave timing used
      op(16'h01F6, 1, 0, 32'h0000_00E0, 8);            // R8 back to master, slave setup
      op(16'h01F0, 1, 0, 32'h0000_5A5A, 5);            // R5 master write word
      op(16'h0176, 1, 0, 32'h0000_0010, 8);            // R8 secondary slave
      op(16'h0170, 0, 1, 32'h0, 2);                    // R2 secondary slave setup 0
      op(16'h0176, 1, 0, 32'h0000_0000, 8);            // R8 secondary master
      op(16'h0170, 0, 1, 32'h0, 2);                    // R2 setup nibble 15, active 18
      op(16'h0172, 0, 1, 32'h0, 6);                    // R6 dword to non-data: single strobe
      op(16'h01F8, 0, 0, 32'h0, 1);                    // R1 out of range
      op(16'h03F6, 1, 0, 32'h0000_0010, 1);            // R1 out of range write
      op(16'h016F, 0, 1, 32'h0, 1);                    // R1 just below secondary
      // R11: hold start high through a dword read on primary
      idle_tag = 11;
      tick(1, 16'h01F0, 0, 1, 32'h0);
      for (int i = 0; i < 80; i++) tick(1, 16'h0172, 1, 0, 32'h1111_0010);
      idle_ticks(40);
      // R4 max nibbles
      setup_pri_i = 8'hFF; rd_tim_i = {8'h4A, 8'hF0, 8'h20, 8'hFF}; cmd_act_i = 4'hF;
      op(16'h01F0, 0, 1, 32'h0, 4);
      op(16'h01F7, 0, 0, 32'h0, 3);                    // R3 max global active
      finish_run();
   end
endmodule